// File: doc/BRIEF.md
# Gated BCD Pulse-Rate Meter

This block reports how fast a shaft turns. It counts encoder pulses over a fixed gate interval that is derived from the system clock. It divides the clock into a one-second gate, or a half-second gate when a parameter selects it. Inside each gate, every rising edge of the synchronized encoder input advances a two-digit decimal (BCD) counter. When the gate closes, the counter value moves into a holding register and the counter starts again from zero. The outputs show only the holding register. A one-cycle strobe marks each new reading.

The held reading is also compared with a setpoint, and the result is given as three flags: equal, greater and lesser. Three select switches choose the setpoint from the fixed values 3, 6 and 9, or zero when no switch is on. A speed loop can use these flags to decide whether to raise or lower a PWM duty cycle. The encoder input must already be free of bounce.

Top module: `pulse_rate_meter`

## Requirements
- R1: `rate_valid_o` pulses once every WIN clock cycles, where WIN = CLK_HZ when HALF_WINDOW = 0 and WIN = CLK_HZ/2 when HALF_WINDOW = 1.
- R2: `rate_valid_o` is high for exactly one cycle: the cycle after the holding register loads.
- R3: `enc_i` passes through two synchronizer flops. Each low-to-high transition adds one to the count. A level that stays high for a whole gate counts once.
- R4: `rate_bcd_o[7:4]` is the tens digit and `rate_bcd_o[3:0]` is the ones digit. The ones digit wraps from 9 to 0 and carries into the tens digit, so ten pulses read as 8'h10.
- R5: The count saturates at 99: extra pulses in the same gate leave it at 8'h99.
- R6: An edge that reaches the counter on the gate-closing cycle is counted in the new gate. An edge that reaches it one cycle earlier is counted in the closing gate.
- R7: `rate_bcd_o` changes only when a gate closes, and it holds its value between gate closings.
- R8: The setpoint is 9 when `sel_i[2]` is 1. Otherwise it is 6 when `sel_i[1]` is 1, otherwise 3 when `sel_i[0]` is 1, otherwise 0.
- R9: Exactly one of `eq_o`, `gt_o` and `lt_o` is high. It shows whether the held reading is equal to, greater than or less than the setpoint.
- R10: While `rst_ni` is low, `rate_bcd_o` is 8'h00 and `rate_valid_o` is 0. After `rst_ni` rises at a clock fall, the first `rate_valid_o` is seen WIN+2 clock falls later: two cycles for reset release and one full gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| enc_i | input | 1 | Encoder pulse input, debounced but not synchronized to the clock |
| sel_i | input | 3 | Setpoint select switches (bit 2 gives 9, bit 1 gives 6, bit 0 gives 3) |
| rate_bcd_o | output | 8 | Held reading: tens digit in bits 7:4, ones digit in bits 3:0 |
| rate_valid_o | output | 1 | One-cycle strobe when a new reading is held |
| eq_o | output | 1 | Held reading equals the setpoint |
| gt_o | output | 1 | Held reading is greater than the setpoint |
| lt_o | output | 1 | Held reading is less than the setpoint |

## Verification
The bench builds two copies of the block with CLK_HZ = 1000, one with HALF_WINDOW = 0 and one with HALF_WINDOW = 1. This gives gates of 1000 and 500 cycles. Gates this short let a run cover the 99 saturation, the ones-to-tens carry, both gate lengths and many compare cases. They are also long enough for 120 four-cycle pulses to fit inside one gate. Because the gate length is small and known exactly, the bench can place a single edge on the closing cycle or one cycle before it. It can also measure the reset-to-first-reading delay to the exact cycle.

// File: rtl/rate_pkg.sv
package rate_pkg;
  typedef struct packed {
    logic [3:0] tens;
    logic [3:0] ones;
  } bcd2_t;

  localparam logic [3:0] DIGIT_MAX = 4'd9;
endpackage

// File: rtl/rate_timebase.sv
module rate_timebase #(
  parameter int unsigned CLK_HZ      = 50_000_000,
  parameter bit          HALF_WINDOW = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic gate_o
);
  localparam int unsigned WIN = HALF_WINDOW ? (CLK_HZ / 2) : CLK_HZ;
  localparam int unsigned CW  = (WIN > 2) ? $clog2(WIN) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    gate_o = (cnt_q == CW'(WIN - 1));
    cnt_d  = gate_o ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // R1
  win_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(WIN - 1));
endmodule

// File: rtl/rate_edge_sync.sv
module rate_edge_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enc_i,
  output logic rise_o
);
  logic [2:0] stg_q, stg_d;

  always_comb begin
    stg_d  = {stg_q[1:0], enc_i};
    rise_o = stg_q[1] & ~stg_q[2];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= stg_d;
  end

  // R3
  single_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/bcd_gate_counter.sv
module bcd_gate_counter
  import rate_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  rise_i,
  input  logic  gate_i,
  output bcd2_t hold_o,
  output logic  load_o
);
  bcd2_t cnt_q, cnt_d, inc, hold_q, hold_d;
  logic  load_q, load_d;

  always_comb begin
    inc = cnt_q;
    if (cnt_q.ones != DIGIT_MAX) begin
      inc.ones = cnt_q.ones + 4'd1;
    end else if (cnt_q.tens != DIGIT_MAX) begin
      inc.ones = 4'd0;
      inc.tens = cnt_q.tens + 4'd1;
    end
  end

  always_comb begin
    hold_d = hold_q;
    load_d = gate_i;
    if (gate_i) begin
      hold_d = cnt_q;
      cnt_d  = rise_i ? bcd2_t'(8'h01) : bcd2_t'(8'h00);
    end else begin
      cnt_d  = rise_i ? inc : cnt_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      hold_q <= '0;
      load_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      hold_q <= hold_d;
      load_q <= load_d;
    end
  end

  assign hold_o = hold_q;
  assign load_o = load_q;

  // R4
  digit_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q.ones <= DIGIT_MAX) && (cnt_q.tens <= DIGIT_MAX));
  // R5
  sat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == bcd2_t'(8'h99) && !gate_i) |=> cnt_q == bcd2_t'(8'h99));
  // R7
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_i |=> $stable(hold_q));
endmodule

// File: rtl/rate_compare.sv
module rate_compare
  import rate_pkg::*;
#(
  parameter logic [3:0] SP_LOW  = 4'd3,
  parameter logic [3:0] SP_MID  = 4'd6,
  parameter logic [3:0] SP_HIGH = 4'd9
) (
  input  bcd2_t      rate_i,
  input  logic [2:0] sel_i,
  output logic       eq_o,
  output logic       gt_o,
  output logic       lt_o
);
  logic [3:0] sp;
  logic [7:0] sp_bcd;

  always_comb begin
    if (sel_i[2])      sp = SP_HIGH;
    else if (sel_i[1]) sp = SP_MID;
    else if (sel_i[0]) sp = SP_LOW;
    else               sp = 4'd0;
    sp_bcd = {4'd0, sp};
    eq_o = (rate_i == sp_bcd);
    gt_o = (rate_i >  sp_bcd);
    lt_o = (rate_i <  sp_bcd);
  end
endmodule

// File: rtl/pulse_rate_meter.sv
module pulse_rate_meter
  import rate_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 50_000_000,
  parameter bit          HALF_WINDOW = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       enc_i,
  input  logic [2:0] sel_i,
  output logic [7:0] rate_bcd_o,
  output logic       rate_valid_o,
  output logic       eq_o,
  output logic       gt_o,
  output logic       lt_o
);
  logic [1:0] rst_sync_q;
  logic       rst_n_int;
  logic       rise, gate;
  bcd2_t      hold;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  rate_timebase #(.CLK_HZ(CLK_HZ), .HALF_WINDOW(HALF_WINDOW)) u_tb (
    .clk_i (clk_i), .rst_ni(rst_n_int), .gate_o(gate));

  rate_edge_sync u_sync (
    .clk_i(clk_i), .rst_ni(rst_n_int), .enc_i(enc_i), .rise_o(rise));

  bcd_gate_counter u_cnt (
    .clk_i(clk_i), .rst_ni(rst_n_int), .rise_i(rise), .gate_i(gate),
    .hold_o(hold), .load_o(rate_valid_o));

  rate_compare u_cmp (
    .rate_i(hold), .sel_i(sel_i), .eq_o(eq_o), .gt_o(gt_o), .lt_o(lt_o));

  assign rate_bcd_o = hold;

  // R2
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    rate_valid_o |=> !rate_valid_o);
  // R9
  flag_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    $countones({eq_o, gt_o, lt_o}) == 1);
  // R7
  out_change_chk: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    !$stable(rate_bcd_o) |-> rate_valid_o);
endmodule

// File: tb/tb_pulse_rate_meter.sv
module tb_pulse_rate_meter;
  localparam int unsigned HZ  = 1000;
  localparam int          WIN = 1000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enc = 1'b0;
  logic [2:0] sel = 3'd0;
  logic [7:0] rate, rate_h;
  logic       valid, valid_h, eq, gt, lt, eq_h, gt_h, lt_h;

  int checks = 0, fails = 0;
  int q[$];
  int carry = 0;
  int last = 0;
  bit mon_en = 1'b1;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pulse_rate_meter #(.CLK_HZ(HZ), .HALF_WINDOW(1'b0)) dut (
    .clk_i(clk), .rst_ni(rst_n), .enc_i(enc), .sel_i(sel),
    .rate_bcd_o(rate), .rate_valid_o(valid), .eq_o(eq), .gt_o(gt), .lt_o(lt));

  pulse_rate_meter #(.CLK_HZ(HZ), .HALF_WINDOW(1'b1)) dut_half (
    .clk_i(clk), .rst_ni(rst_n), .enc_i(enc), .sel_i(sel),
    .rate_bcd_o(rate_h), .rate_valid_o(valid_h), .eq_o(eq_h), .gt_o(gt_h), .lt_o(lt_h));

  function automatic logic [7:0] to_bcd(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  // monitor: pops the expected reading at every strobe
  always @(negedge clk) begin
    if (mon_en && valid && q.size() > 0) begin
      int e;
      e = q.pop_front();
      check(rate == to_bcd(e), "R4/R5/R6 reading", rate, to_bcd(e));
    end
  end

  // strobe period of both builds, first three intervals
  int gap_f = 0, gap_h = 0, seen_f = 0, seen_h = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      gap_f++; gap_h++;
      if (valid) begin
        if (seen_f > 0 && seen_f < 4) check(gap_f == WIN, "R1 full gate period", gap_f, WIN);
        if (seen_f > 0 && seen_f < 4) check(!$isunknown(rate), "R2 strobe", valid, 1);
        seen_f++; gap_f = 0;
      end
      if (valid_h) begin
        if (seen_h > 0 && seen_h < 4) check(gap_h == WIN / 2, "R1 half gate period", gap_h, WIN / 2);
        seen_h++; gap_h = 0;
      end
    end
  end

  // R2: strobe never lasts two sampled cycles
  logic valid_d = 1'b0;
  always @(negedge clk) begin
    if (rst_n && valid && valid_d) check(1'b0, "R2 one-cycle strobe", 2, 1);
    valid_d = valid;
  end

  task automatic wait_valid();
    do @(negedge clk); while (!valid);
  endtask

  // mode 0 normal, 1 level held high, 3 edge on closing cycle, 4 edge one cycle earlier
  task automatic window(input int n, input int mode);
    int cur;
    wait_valid();
    #1;
    cur = n + carry;
    carry = 0;
    if (mode == 1) cur = cur + 1;
    if (mode == 4) cur = cur + 1;
    if (mode == 3) carry = 1;
    if (cur > 99) cur = 99;
    q.push_back(cur);
    last = cur;
    for (int i = 0; i < n; i++) begin
      enc = 1'b1; repeat (2) @(negedge clk);
      enc = 1'b0; repeat (2) @(negedge clk);
    end
    if (mode == 1) begin
      enc = 1'b1; repeat (WIN - 10) @(negedge clk); enc = 1'b0;
    end else if (mode == 3 || mode == 4) begin
      repeat (WIN - mode - 4 * n) @(negedge clk);
      enc = 1'b1; repeat (2) @(negedge clk); enc = 1'b0;
    end
  endtask

  // R8, R9: walks every select pattern against the held reading
  task automatic settle();
    int sp;
    wait_valid();
    #1;
    q.push_back(carry);
    last = carry;
    for (int s = 0; s < 8; s++) begin
      sel = 3'(s);
      sp = s[2] ? 9 : (s[1] ? 6 : (s[0] ? 3 : 0));
      @(negedge clk);
      check(eq == (rate == to_bcd(sp)) && gt == (rate > to_bcd(sp)) && lt == (rate < to_bcd(sp)),
            "R8/R9 compare flags", {eq, gt, lt}, {rate == to_bcd(sp), rate > to_bcd(sp), rate < to_bcd(sp)});
    end
    sel = 3'd0;
    carry = 0;
  endtask

  initial begin
    int n;
    repeat (4) @(negedge clk);
    check(rate == 8'h00 && valid == 1'b0, "R10 reset state", {valid, rate}, 0);
    rst_n = 1'b1;
    window(5, 0);
    window(10, 0);   // R4 carry -> 8'h10
    window(9, 0);
    window(99, 0);   // R5 exact top
    window(120, 0);  // R5 saturation
    window(0, 1);    // R3 level counts once
    window(0, 3);    // R6 closing-cycle edge goes to next gate
    window(7, 0);    // receives the carried edge -> 8
    window(0, 4);    // R6 edge one cycle earlier stays
    window(6, 0);
    settle();        // held 6
    window(12, 0);
    settle();        // held 12
    window(0, 0);
    wait_valid();
    #1;
    mon_en = 1'b0;
    q.delete();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(rate == 8'h00 && valid == 1'b0, "R10 reset clears reading", {valid, rate}, 0);
    check(eq == 1'b1, "R10/R9 eq with zero setpoint", eq, 1);
    @(negedge clk);
    rst_n = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!valid);
    check(n == WIN + 2, "R10 first strobe after reset", n, WIN + 2);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 100000, 0);
    finish_run();
  end
endmodule